// File: doc/BRIEF.md
# Dual-Channel Serial DAC Front End with Chain Pass-Through

This block is the digital front end of a two-channel, 10-bit digital-to-analog converter. A host writes 16-bit command words over a three-wire serial link: a frame-select line (active low), a serial clock and a data line. Each committed word updates one channel's input register. A load line (active low) moves both input registers into the DAC registers together. The two DAC register values are the block's outputs.

A mode pin chooses between two framing schemes. In standalone mode the block takes exactly sixteen clocks per frame and ignores any extra clocks. In chain mode every clock shifts the register while the frame is open. Bits pushed out of the top of the register appear on the serial output, which feeds the data input of the next device. The word is committed when the frame closes. All serial inputs are re-timed into the system clock with two-flop synchronizers, and edges are detected in that domain. The system clock must run at least four times faster than the serial clock.

The frame controller has three states. `ST_IDLE` means no frame is open. `ST_SHIFT` means the frame is open and bits are being accepted. `ST_HOLD` means a standalone frame is full and further clocks are ignored. The transitions are:
- `ST_IDLE` to `ST_SHIFT` on a falling frame-select edge. This clears the shift register, the bit counter and the serial output.
- `ST_SHIFT` to `ST_HOLD` on the sixteenth rising clock edge in standalone mode. The word is committed on this edge.
- `ST_SHIFT` to `ST_IDLE` on a rising frame-select edge. In chain mode the word is committed here if at least sixteen clocks have arrived; otherwise the frame is dropped.
- `ST_HOLD` to `ST_IDLE` on a rising frame-select edge.

Top module: `dual_dac_serial_if`

## Requirements
- R1: After reset, both DAC outputs read 0 and the serial output is low.
- R2: The first data bit clocked in is word bit 15, and bit 15 selects the channel (0 = A, 1 = B). Bits 11:2 carry the 10-bit code, MSB first. Bits 14:12 and 1:0 have no effect on the written value, and the other channel is left unchanged.
- R3: In standalone mode (mode pin low), the word is committed on the 16th rising serial clock of a frame. Clock pulses after the 16th have no effect on the committed word.
- R4: In standalone mode, the serial output stays low.
- R5: A frame that closes after fewer than 16 rising serial clocks writes nothing, in either mode.
- R6: In chain mode (mode pin high), every rising serial clock while frame-select is low shifts the register. On the rising frame-select edge, the last 16 bits shifted in are committed.
- R7: In chain mode, the serial output changes only after a falling serial clock. Before rising clock k of a frame (counting from 0), it shows data bit k−16 of that frame, or 0 when k < 16.
- R8: Serial clock pulses while frame-select is high change nothing.
- R9: While the load line is high, DAC outputs hold even as input registers are written. Driving it low moves both input registers to the outputs together.
- R10: While the load line is held low, each committed word reaches its DAC output without any further action.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chain_en | input | 1 | 1 = chain mode, 0 = standalone mode |
| ser_clk | input | 1 | Serial clock; data is sampled on its rising edge |
| frame_n | input | 1 | Frame select, active low |
| ser_din | input | 1 | Serial data in |
| load_n | input | 1 | Load strobe, active low, level-sensitive |
| ser_dout | output | 1 | Serial data out to the next device in the chain |
| dac_a | output | 10 | DAC register value, channel A |
| dac_b | output | 10 | DAC register value, channel B |

## Verification
Several properties are checked on every cycle by assertions:
- a full standalone frame never counts past sixteen;
- a commit lasts exactly one cycle;
- the shift register moves only in `ST_SHIFT` or at frame start;
- a DAC register never changes in a cycle where the load line was high;
- a write to one channel leaves the other channel's input register untouched;
- the serial output stays low in standalone mode.

Other behaviour can only be shown by the bench's scenarios. These include the bit ordering and field placement across a sweep of codes, discarding extra clocks and short frames, the sixteen-clock delay of the chain output, and committing the last word of a long chain stream.

// File: rtl/dacif_pkg.sv
package dacif_pkg;
    localparam int WORD_W   = 16;
    localparam int CODE_W   = 10;
    localparam int CHAN_BIT = 15;
    localparam int CODE_LSB = 2;
    localparam int CODE_MSB = CODE_LSB + CODE_W - 1;
    localparam int NUM_CH   = 2;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_HOLD  = 2'd2
    } frame_state_t;
endpackage

// File: rtl/dacif_sync.sv
module dacif_sync #(
    parameter int              WIDTH   = 4,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] pipe [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) pipe[i] <= RST_VAL;
        end else begin
            pipe[0] <= d;
            for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/dacif_frame.sv
module dacif_frame
    import dacif_pkg::*;
#(
    parameter int W_WORD = WORD_W,
    parameter int W_CODE = CODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chain_en,
    input  logic              sclk_rise,
    input  logic              sclk_fall,
    input  logic              frame_fall,
    input  logic              frame_rise,
    input  logic              din_s,
    output logic              commit_q,
    output logic              commit_chan_q,
    output logic [W_CODE-1:0] commit_code_q,
    output logic              sdo_q
);
    localparam int CNT_W = $clog2(W_WORD + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(W_WORD);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(W_WORD - 1);

    frame_state_t     state, nxt;
    logic [W_WORD-1:0] shreg;
    logic [W_WORD-1:0] shreg_next;
    logic [CNT_W-1:0]  cnt;
    logic              frame_start;
    logic              sa_commit;
    logic              ch_commit;

    assign shreg_next  = {shreg[W_WORD-2:0], din_s};
    assign frame_start = (state == ST_IDLE) && frame_fall;
    assign sa_commit   = (state == ST_SHIFT) && !chain_en && sclk_rise && (cnt == CNT_LAST);
    assign ch_commit   = (state == ST_SHIFT) && chain_en && frame_rise && (cnt == CNT_FULL);

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (frame_fall) nxt = ST_SHIFT;
            ST_SHIFT: begin
                if (frame_rise)     nxt = ST_IDLE;
                else if (sa_commit) nxt = ST_HOLD;
            end
            ST_HOLD:  if (frame_rise) nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg         <= '0;
            cnt           <= '0;
            sdo_q         <= 1'b0;
            commit_q      <= 1'b0;
            commit_chan_q <= 1'b0;
            commit_code_q <= '0;
        end else begin
            commit_q <= sa_commit || ch_commit;
            if (sa_commit) begin
                commit_chan_q <= shreg_next[CHAN_BIT];
                commit_code_q <= shreg_next[CODE_MSB:CODE_LSB];
            end else if (ch_commit) begin
                commit_chan_q <= shreg[CHAN_BIT];
                commit_code_q <= shreg[CODE_MSB:CODE_LSB];
            end

            if (frame_start) begin
                shreg <= '0;
                cnt   <= '0;
            end else if ((state == ST_SHIFT) && sclk_rise) begin
                shreg <= shreg_next;
                if (cnt != CNT_FULL) cnt <= cnt + 1'b1;
            end

            if (!chain_en)                                 sdo_q <= 1'b0;
            else if (frame_start)                          sdo_q <= 1'b0;
            else if ((state == ST_SHIFT) && sclk_fall)     sdo_q <= shreg[W_WORD-1];
        end
    end

    // R3: a full standalone frame never counts past the word width
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD) |-> (cnt == CNT_FULL));

    // R3, R6: a commit lasts exactly one cycle
    a_r6_single_commit: assert property (@(posedge clk) disable iff (!rst_n)
        commit_q |=> !commit_q);

    // R8: the register moves only inside an open frame or at its start
    a_r8_shift_gated: assert property (@(posedge clk) disable iff (!rst_n)
        ((state != ST_SHIFT) && !frame_start) |=> $stable(shreg));
endmodule

// File: rtl/dacif_regs.sv
module dacif_regs
    import dacif_pkg::*;
#(
    parameter int W_CODE = CODE_W,
    parameter int N_CH   = NUM_CH
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [$clog2(N_CH)-1:0]      wr_chan,
    input  logic [W_CODE-1:0]            wr_code,
    input  logic                         load_n_s,
    output logic [N_CH-1:0][W_CODE-1:0]  dac_codes
);
    logic [N_CH-1:0][W_CODE-1:0] in_q;

    for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                in_q[ch]      <= '0;
                dac_codes[ch] <= '0;
            end else begin
                if (wr_en && (wr_chan == ch)) in_q[ch] <= wr_code;
                if (!load_n_s)                dac_codes[ch] <= in_q[ch];
            end
        end

        // R2: a write addressed elsewhere leaves this channel's input register alone
        a_r2_chan_isolation: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && (wr_chan != ch)) |=> $stable(in_q[ch]));

        // R9: outputs hold while the load line is high
        a_r9_hold_when_unloaded: assert property (@(posedge clk) disable iff (!rst_n)
            load_n_s |=> $stable(dac_codes[ch]));
    end
endmodule

// File: rtl/dual_dac_serial_if.sv
module dual_dac_serial_if
    import dacif_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chain_en,
    input  logic              ser_clk,
    input  logic              frame_n,
    input  logic              ser_din,
    input  logic              load_n,
    output logic              ser_dout,
    output logic [CODE_W-1:0] dac_a,
    output logic [CODE_W-1:0] dac_b
);
    localparam int IDX_SCLK  = 0;
    localparam int IDX_FRAME = 1;
    localparam int IDX_DIN   = 2;
    localparam int IDX_LOAD  = 3;
    localparam logic [3:0] IN_RST = 4'b1010;

    logic [3:0] raw_in, sync_in;
    logic       sclk_prev, frame_prev;
    logic       sclk_rise, sclk_fall, frame_rise, frame_fall;
    logic       commit, commit_chan;
    logic [CODE_W-1:0]             commit_code;
    logic [NUM_CH-1:0][CODE_W-1:0] dac_codes;

    assign raw_in = {load_n, ser_din, frame_n, ser_clk};

    dacif_sync #(.WIDTH(4), .STAGES(SYNC_STAGES), .RST_VAL(IN_RST)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_in),
        .q     (sync_in)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_prev  <= 1'b0;
            frame_prev <= 1'b1;
        end else begin
            sclk_prev  <= sync_in[IDX_SCLK];
            frame_prev <= sync_in[IDX_FRAME];
        end
    end

    assign sclk_rise  =  sync_in[IDX_SCLK]  && !sclk_prev;
    assign sclk_fall  = !sync_in[IDX_SCLK]  &&  sclk_prev;
    assign frame_rise =  sync_in[IDX_FRAME] && !frame_prev;
    assign frame_fall = !sync_in[IDX_FRAME] &&  frame_prev;

    dacif_frame #(.W_WORD(WORD_W), .W_CODE(CODE_W)) u_frame (
        .clk           (clk),
        .rst_n         (rst_n),
        .chain_en      (chain_en),
        .sclk_rise     (sclk_rise),
        .sclk_fall     (sclk_fall),
        .frame_fall    (frame_fall),
        .frame_rise    (frame_rise),
        .din_s         (sync_in[IDX_DIN]),
        .commit_q      (commit),
        .commit_chan_q (commit_chan),
        .commit_code_q (commit_code),
        .sdo_q         (ser_dout)
    );

    dacif_regs #(.W_CODE(CODE_W), .N_CH(NUM_CH)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (commit),
        .wr_chan   (commit_chan),
        .wr_code   (commit_code),
        .load_n_s  (sync_in[IDX_LOAD]),
        .dac_codes (dac_codes)
    );

    assign dac_a = dac_codes[0];
    assign dac_b = dac_codes[1];

    // R4: standalone mode keeps the serial output low
    a_r4_sdo_low_standalone: assert property (@(posedge clk) disable iff (!rst_n)
        !chain_en |=> !ser_dout);
endmodule

// File: tb/tb_dual_dac_serial_if.sv
module tb_dual_dac_serial_if;
    localparam int HALF = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic chain_en = 1'b0;
    logic ser_clk = 1'b0;
    logic frame_n = 1'b1;
    logic ser_din = 1'b0;
    logic load_n = 1'b1;
    logic ser_dout;
    logic [9:0] dac_a, dac_b;

    int errors = 0;
    int checks = 0;
    bit done = 0;
    logic [9:0] exp_in [2];
    logic [9:0] exp_dac [2];

    always #5 clk = ~clk;

    dual_dac_serial_if dut (
        .clk(clk), .rst_n(rst_n), .chain_en(chain_en), .ser_clk(ser_clk),
        .frame_n(frame_n), .ser_din(ser_din), .load_n(load_n),
        .ser_dout(ser_dout), .dac_a(dac_a), .dac_b(dac_b)
    );

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(input logic d, output logic so);
        ser_din = d;
        wait_clk(HALF);
        so = ser_dout;
        ser_clk = 1'b1;
        wait_clk(HALF);
        ser_clk = 1'b0;
    endtask

    task automatic send(input logic [63:0] bits, input int n, output logic [63:0] so_bits);
        logic s;
        so_bits = '0;
        frame_n = 1'b0;
        wait_clk(HALF);
        for (int i = 0; i < n; i++) begin
            pulse(bits[n-1-i], s);
            so_bits[n-1-i] = s;
        end
        wait_clk(HALF);
        frame_n = 1'b1;
        wait_clk(2 * HALF);
    endtask

    function automatic logic [15:0] mk(input logic ch, input logic [9:0] code, input logic [4:0] junk);
        return {ch, junk[4:2], code, junk[1:0]};
    endfunction

    task automatic check_outs(input string req, input string what);
        check(req, {what, " dac_a"}, {54'b0, dac_a}, {54'b0, exp_dac[0]});
        check(req, {what, " dac_b"}, {54'b0, dac_b}, {54'b0, exp_dac[1]});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [63:0] so;
        logic [63:0] s48;
        logic [15:0] w;
        logic [9:0]  code;
        int          sdo_bad;
        exp_in[0] = '0; exp_in[1] = '0; exp_dac[0] = '0; exp_dac[1] = '0;
        wait_clk(4);
        rst_n = 1'b1;
        wait_clk(4);

        // R1 reset state
        check("R1", "reset ser_dout", {63'b0, ser_dout}, 64'd0);
        check_outs("R1", "reset");

        // R2 R3 R4 R10: sweep of codes with load held low, junk in ignored bits
        load_n = 1'b0;
        sdo_bad = 0;
        for (int i = 0; i < 66; i++) begin
            logic ch;
            code = (i == 65) ? 10'h3FF : 10'((i * 17 + 5) % 1024);
            ch   = 1'(i % 2);
            w    = mk(ch, code, 5'(i * 7));
            send({48'b0, w}, 16, so);
            if (so != 64'd0) sdo_bad++;
            exp_in[ch] = code; exp_dac[ch] = code;
            check_outs("R2/R10", $sformatf("sweep %0d", i));
        end
        check("R4", "standalone sdo frames nonzero", 64'(sdo_bad), 64'd0);

        // R8: clocks with frame high change nothing
        for (int i = 0; i < 20; i++) pulse(1'b1, so[0]);
        wait_clk(4 * HALF);
        check_outs("R8", "clocks without frame");

        // R3: extra clocks after the 16th are ignored
        w = mk(1'b0, 10'h2A5, 5'b0);
        send({44'b0, w, 4'b1111}, 20, so);
        exp_in[0] = 10'h2A5; exp_dac[0] = 10'h2A5;
        check_outs("R3", "20 clocks standalone");

        // R5: short standalone frame dropped
        send({54'b0, 10'h3FF}, 10, so);
        check_outs("R5", "short standalone");

        // R9: writes with load high do not reach outputs until load falls
        load_n = 1'b1;
        wait_clk(HALF);
        send({48'b0, mk(1'b0, 10'h111, 5'b0)}, 16, so);
        send({48'b0, mk(1'b1, 10'h2EE, 5'b0)}, 16, so);
        exp_in[0] = 10'h111; exp_in[1] = 10'h2EE;
        check_outs("R9", "load high hold");
        load_n = 1'b0;
        wait_clk(HALF);
        exp_dac[0] = exp_in[0]; exp_dac[1] = exp_in[1];
        check_outs("R9", "load low both");

        // R6 R7: chain stream of three words, last one committed
        chain_en = 1'b1;
        wait_clk(HALF);
        s48 = {16'b0, mk(1'b1, 10'h0F0, 5'b10110), mk(1'b0, 10'h155, 5'b01001), mk(1'b1, 10'h3C3, 5'b11111)};
        send(s48, 48, so);
        check("R7", "chain sdo stream", so, s48 >> 16);
        exp_in[1] = 10'h3C3; exp_dac[1] = 10'h3C3;
        check_outs("R6", "chain 48 clocks");

        // R6: exactly 16 clocks in chain mode
        w = mk(1'b0, 10'h00F, 5'b0);
        send({48'b0, w}, 16, so);
        check("R7", "chain 16 sdo zero", so, 64'd0);
        exp_in[0] = 10'h00F; exp_dac[0] = 10'h00F;
        check_outs("R6", "chain 16 clocks");

        // R5: short chain frame dropped
        send({52'b0, 12'hFFF}, 12, so);
        check_outs("R5", "short chain");

        // R6: 17 clocks, last 16 committed
        w = mk(1'b1, 10'h200, 5'b0);
        send({47'b0, 1'b1, w}, 17, so);
        check("R7", "chain 17 sdo", so, 64'd1);
        exp_in[1] = 10'h200; exp_dac[1] = 10'h200;
        check_outs("R6", "chain 17 clocks");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule